// File: doc/BRIEF.md
# Receive Buffer with Line Status

This block sits between a serial receiver and the CPU-facing register file of an asynchronous serial port. Each finished character arrives with two error tags, one for parity and one for framing. The block holds these characters. It presents the oldest one on `rx_data`, and it drives a four-bit status word that a register read returns. `line_status` bit 0 is data ready, bit 1 is overrun, bit 2 is parity error and bit 3 is framing error.

The block has two modes. With `fifo_mode` low, it holds a single character. A new character that arrives while that one is unread replaces it, and the parity and framing flags collect sticky across characters. With `fifo_mode` high, a 16-entry queue keeps the tags next to each character. The parity and framing bits then describe only the character at the head of the queue. A read of the status word (`rd_status`) clears the error indications. A read of the data (`rd_data`) removes the head character.

The receive side uses a valid/ready pair, but the receiver cannot be held off. `in_ready` is only a hint that space exists. If a character is presented while `in_ready` is low and no data read happens in the same cycle, it is an overrun. Nothing is stalled. In FIFO mode the incoming character is dropped. In single mode it overwrites the held character.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset `line_status` is 4'b0000, `rx_data` is 0 and `in_ready` is 1. The block starts in single mode.
- R2: `line_status[0]` is 1 exactly when at least one character is held. `rx_data` shows the oldest held character, or 0 when nothing is held.
- R3: In FIFO mode, up to DEPTH (16) characters are kept and handed out in arrival order. The head does not change unless `rd_data` removes it.
- R4: In FIFO mode, a character that arrives while the queue is full and no data read happens is dropped. The stored characters stay as they were, and the overrun bit (`line_status[1]`) sets.
- R5: In single mode, a character that arrives while the held character is unread replaces it and sets the overrun bit.
- R6: When `rd_data` and `in_valid` occur in the same cycle, the head is removed and the new character is stored. This is not an overrun, even when the buffer is full.
- R7: The overrun bit stays set, even after the buffer drains, until a `rd_status` cycle in which no new overrun occurs. A new overrun in that cycle leaves it set.
- R8: In FIFO mode, `line_status[2]` and `line_status[3]` give the parity and framing tags of the head character. After a `rd_status` they read 0 until the head changes. They are 0 when the queue is empty.
- R9: In single mode, `line_status[2]` and `line_status[3]` are sticky. Any accepted character with the matching tag sets them, and `rd_status` clears them. A tag that is accepted in the same cycle as `rd_status` still sets the bit.
- R10: In a cycle where `fifo_mode` differs from its value in the previous cycle, all held characters and all error flags are cleared, and a character presented in that cycle is discarded.
- R11: `in_ready` is 1 when fewer characters are held than the capacity of the current mode (1 in single mode, DEPTH in FIFO mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 = queue mode, 0 = single holding register |
| in_valid | input | 1 | A received character is presented this cycle |
| in_ready | output | 1 | Space is available (advisory, never stalls) |
| in_data | input | 8 | Received character |
| in_perr | input | 1 | Parity error tag of the presented character |
| in_ferr | input | 1 | Framing error tag of the presented character |
| rd_data | input | 1 | CPU read of the receive data, pops the head |
| rd_status | input | 1 | CPU read of the status word, clears error flags |
| rx_data | output | 8 | Head character |
| line_status | output | 4 | {framing, parity, overrun, data ready} |

## Verification
The bench fills the queue to 16 and pushes one more character. A design that accepted that character would wrap its pointers and lose the oldest one. It also reads and writes in the same cycle while the queue is full, where a wrong design would report a false overrun or drift its count. It lets an overrun survive a full drain before the status read, and it toggles the mode with a character in flight. Sticky error flags and flags tied to the head are compared character by character. A design that mixed the two would show a framing error on the wrong entry, or lose one that was set in the same cycle as a status read.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 4;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  // status bit positions
  localparam int ST_DR = 0;
  localparam int ST_OE = 1;
  localparam int ST_PE = 2;
  localparam int ST_FE = 3;
endpackage

// File: rtl/rxs_store.sv
module rxs_store #(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/rxs_flags.sv
module rxs_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       flush,
  input  logic       ovr_evt,
  input  logic       accept,
  input  logic       head_change,
  input  logic       rd_status,
  input  logic       in_perr,
  input  logic       in_ferr,
  input  logic       nonempty,
  input  logic       head_perr,
  input  logic       head_ferr,
  output logic [3:0] status
);
  import rxs_pkg::*;

  logic oe_q, pe_stk, fe_stk, seen_q;
  logic take_tags;

  assign take_tags = accept && !fifo_mode;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      oe_q   <= 1'b0;
      pe_stk <= 1'b0;
      fe_stk <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (ovr_evt)        oe_q <= 1'b1;
      else if (rd_status) oe_q <= 1'b0;
      pe_stk <= (pe_stk && !rd_status) || (take_tags && in_perr);
      fe_stk <= (fe_stk && !rd_status) || (take_tags && in_ferr);
      if (head_change)    seen_q <= 1'b0;
      else if (rd_status) seen_q <= 1'b1;
    end
  end

  always_comb begin
    status        = '0;
    status[ST_DR] = nonempty;
    status[ST_OE] = oe_q;
    if (fifo_mode) begin
      status[ST_PE] = nonempty && head_perr && !seen_q;
      status[ST_FE] = nonempty && head_ferr && !seen_q;
    end else begin
      status[ST_PE] = pe_stk;
      status[ST_FE] = fe_stk;
    end
  end
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_perr,
  input  logic       in_ferr,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] rx_data,
  output logic [3:0] line_status
);
  import rxs_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic          mode_q, flush;
  logic [CW-1:0] count, cap;
  logic          nonempty, full, pop_req, pop_int, push, ovr_evt, head_change;
  rx_entry_t     wr_ent, head_ent;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end

  assign flush    = (fifo_mode != mode_q);
  assign cap      = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign nonempty = (count != '0);
  assign full     = (count >= cap);
  assign in_ready = !full;

  // single mode overwrites the held character instead of dropping
  assign pop_req     = rd_data && nonempty && !flush;
  assign ovr_evt     = in_valid && full && !pop_req && !flush;
  assign pop_int     = pop_req || (ovr_evt && !fifo_mode);
  assign push        = in_valid && !flush && (!full || pop_int);
  assign head_change = pop_int || (push && !nonempty);

  assign wr_ent = '{ferr: in_ferr, perr: in_perr, data: in_data};

  rxs_store #(.DEPTH(DEPTH), .W(ENTRY_W), .CW(CW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop_int),
    .wdata (wr_ent),
    .head  (head_ent),
    .count (count)
  );

  rxs_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_mode   (fifo_mode),
    .flush       (flush),
    .ovr_evt     (ovr_evt),
    .accept      (push),
    .head_change (head_change),
    .rd_status   (rd_status),
    .in_perr     (in_perr),
    .in_ferr     (in_ferr),
    .nonempty    (nonempty),
    .head_perr   (head_ent.perr),
    .head_ferr   (head_ent.ferr),
    .status      (line_status)
  );

  assign rx_data = nonempty ? head_ent.data : '0;
endmodule

// File: rtl/rx_status_fifo_chk.sv
module rx_status_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_mode,
  input logic       in_valid,
  input logic       in_ready,
  input logic       rd_data,
  input logic       rd_status,
  input logic [7:0] rx_data,
  input logic [3:0] line_status,
  input logic       flush
);
  assert_read_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !fifo_mode && !in_valid) |=> !line_status[0]);

  assert_head_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && line_status[0] && !rd_data && !flush) |=> $stable(rx_data));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !rd_data && !flush) |=> line_status[1]);

  assert_oe_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !(in_valid && !in_ready && !rd_data)) |=> !line_status[1]);

  assert_empty_tags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !flush && !line_status[0]) |-> (line_status[3:2] == 2'b00));

  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (line_status == 4'b0000));

  assert_ready_space_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> line_status[0]);
endmodule

bind rx_status_fifo rx_status_fifo_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_mode   (fifo_mode),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .rd_data     (rd_data),
  .rd_status   (rd_status),
  .rx_data     (rx_data),
  .line_status (line_status),
  .flush       (flush)
);

// File: tb/rx_status_fifo_test.sv
module rx_status_fifo_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_mode = 1'b0, in_valid = 1'b0, in_perr = 1'b0, in_ferr = 1'b0;
  logic       rd_data = 1'b0, rd_status = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic [7:0] rx_data;
  logic [3:0] line_status;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  rx_status_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_perr(in_perr), .in_ferr(in_ferr),
    .rd_data(rd_data), .rd_status(rd_status), .rx_data(rx_data),
    .line_status(line_status)
  );

  // reference state, built from the requirements
  logic [9:0] q[$];
  logic m_mode = 1'b0, m_oe = 1'b0, m_pe = 1'b0, m_fe = 1'b0, m_seen = 1'b0;

  function automatic int capacity(input logic fm);
    return fm ? DEPTH : 1;
  endfunction

  function automatic logic [3:0] exp_status();
    logic ne;
    logic [3:0] s;
    ne = (q.size() > 0);
    s  = {2'b00, m_oe, ne};
    if (fifo_mode) begin
      s[2] = ne && q[0][8] && !m_seen;
      s[3] = ne && q[0][9] && !m_seen;
    end else begin
      s[2] = m_pe;
      s[3] = m_fe;
    end
    return s;
  endfunction

  function automatic logic [7:0] exp_data();
    return (q.size() > 0) ? q[0][7:0] : 8'h00;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [3:0] es;
    es = exp_status();
    cmp("R2 data ready", line_status[0], es[0]);
    cmp("R3 head data", rx_data, exp_data());
    cmp("R7 overrun", line_status[1], es[1]);
    if (fifo_mode) cmp("R8 head tags", line_status[3:2], es[3:2]);
    else           cmp("R9 sticky tags", line_status[3:2], es[3:2]);
    cmp("R11 in_ready", in_ready, (q.size() < capacity(fifo_mode)));
  endtask

  task automatic model_edge();
    int  cap;
    logic full, pop, ovr, popi, push, hc;
    if (fifo_mode != m_mode) begin
      q.delete();
      m_oe = 0; m_pe = 0; m_fe = 0; m_seen = 0;
      m_mode = fifo_mode;
      return;
    end
    cap  = capacity(fifo_mode);
    full = (q.size() >= cap);
    pop  = rd_data && (q.size() > 0);
    ovr  = in_valid && full && !pop;
    popi = pop || (ovr && !fifo_mode);
    push = in_valid && (!full || popi);
    hc   = popi || (push && q.size() == 0);
    if (ovr) m_oe = 1; else if (rd_status) m_oe = 0;
    m_pe = (m_pe && !rd_status) || (push && in_perr && !fifo_mode);
    m_fe = (m_fe && !rd_status) || (push && in_ferr && !fifo_mode);
    if (hc) m_seen = 0; else if (rd_status) m_seen = 1;
    if (popi) void'(q.pop_front());
    if (push) q.push_back({in_ferr, in_perr, in_data});
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic p, input logic f,
                      input logic rd, input logic rs, input logic fm);
    in_valid = v; in_data = d; in_perr = p; in_ferr = f;
    rd_data = rd; rd_status = rs; fifo_mode = fm;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 reset status", line_status, 0);
    cmp("R1 reset data", rx_data, 0);
    cmp("R1 reset ready", in_ready, 1);

    // single mode: overwrite and sticky tags
    step(1, 8'hA1, 1, 0, 0, 0, 0);
    step(1, 8'hB2, 0, 0, 0, 0, 0);
    cmp("R5 overwritten data", rx_data, 8'hB2);
    cmp("R5 overrun set", line_status[1], 1);
    cmp("R9 parity kept sticky", line_status[2], 1);
    step(0, 0, 0, 0, 0, 1, 0);
    cmp("R7 overrun cleared", line_status[1], 0);
    cmp("R9 parity cleared", line_status[2], 0);
    step(1, 8'hC3, 0, 1, 0, 1, 0); // replace with framing tag during status read
    cmp("R9 tag set wins over read", line_status[3], 1);

    // mode change discards
    step(1, 8'hD4, 0, 0, 0, 0, 1);
    cmp("R10 flushed", line_status, 0);
    cmp("R10 data dropped", rx_data, 0);

    // fill the queue
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h10 + i), 0, (i == 0), 0, 0, 1);
    cmp("R11 full not ready", in_ready, 0);
    cmp("R8 head framing", line_status[3], 1);
    step(0, 0, 0, 0, 0, 1, 1);
    cmp("R8 hidden after status read", line_status[3], 0);
    step(1, 8'hEE, 0, 0, 0, 0, 1);
    cmp("R4 stored kept", rx_data, 8'h10);
    cmp("R4 overrun set", line_status[1], 1);
    step(1, 8'h77, 0, 0, 1, 0, 1);
    cmp("R6 head advanced", rx_data, 8'h11);
    cmp("R6 still full", in_ready, 0);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, 0, 1);
    cmp("R3 drained", line_status[0], 0);
    cmp("R7 overrun survives drain", line_status[1], 1);
    step(0, 0, 0, 0, 0, 1, 1);
    cmp("R7 cleared by read", line_status[1], 0);

    // random traffic
    void'($urandom(32'h1F2E3D4C));
    for (int n = 0; n < 3000; n++) begin
      logic fm;
      int   rdp;
      fm  = (($urandom % 250) == 0) ? ~fifo_mode : fifo_mode;
      rdp = ((n / 500) % 2 == 0) ? 25 : 60;
      step(($urandom % 100) < 55, 8'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0,
           ($urandom % 100) < rdp, ($urandom % 10) == 0, fm);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule